// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side front end of a serial flash device. It runs on the serial clock, treats the rising edge of chip select as an asynchronous clear, and turns the first byte of each transaction into a command. It decides how many IO lines carry that byte, the address and the data, and it raises the output enables for the IO pins only when the device must drive read data.

The block holds one persistent flag that selects between two framings. In the SPI family the command byte arrives serially on IO0. In the four-wire command mode (QPI) it arrives as two nibbles across all four lines. Two commands enter and leave QPI, and a reset command also leaves it. Entry into QPI, and every command that turns the protect and hold pins into data lanes IO2 and IO3, is allowed only while the Quad Enable input is high.

The controller is a state machine with these states. ST_OPCODE collects the command. ST_ADDR counts address clocks. ST_DUMMY counts wait clocks. ST_DATA_IN is the data phase of a write, and ST_DATA_OUT is the data phase of a read. ST_DONE holds a command that has no address. ST_IGNORE holds a rejected command. The transitions are:
- ST_OPCODE goes to ST_IGNORE on an unknown or disallowed byte, to ST_DONE on a command with no address, and to ST_ADDR otherwise.
- ST_ADDR goes to ST_DUMMY when wait clocks remain, and otherwise straight to a data state.
- ST_DUMMY goes to ST_DATA_IN or ST_DATA_OUT.
- Every state returns to ST_OPCODE when chip select rises.

Top module: `fsf_cmd_frontend`

## Requirements
- R1: Lines are sampled on the rising serial-clock edge and `io_oe` changes only on the falling edge. Both idle-low (mode 0) and idle-high (mode 3) clocks work.
- R2: In the SPI family the command takes 8 clocks, most significant bit first on IO0. `cmd_opcode` holds the byte after the 8th rising edge, and `cmd_lanes` reads 0. The lane encoding is 0 = one line, 1 = two lines, 2 = four lines. Command 0x02 writes over one lane (address and data lanes 0) and never drives a line.
- R3: In QPI the command takes 2 clocks, high nibble first, with IO3 as the most significant bit of each nibble. `cmd_lanes` reads 2.
- R4: Command 0x38 with Quad Enable high sets `qpi_mode`. With Quad Enable low it is rejected: `cmd_valid` stays 0 and the mode does not change.
- R5: Command 0xFF, command 0x99 and a low `por_n` all clear `qpi_mode`.
- R6: Command 0x3B has a one-lane address, 8 wait clocks and two-lane read data. Command 0xBB has a two-lane address (12 clocks), 4 wait clocks and two-lane read data. During their data phase `io_oe` is 4'b0011, where bit i enables IO i.
- R7: With Quad Enable high, commands 0x6B (one-lane address, 8 wait clocks), 0xEB (four-lane address of 6 clocks, 6 wait clocks) and 0xE7 (four-lane address, 4 wait clocks) read over four lanes with `io_oe` = 4'hF. Command 0x32 takes a one-lane address and four-lane write data, and `io_oe` stays 0.
- R8: A four-lane command received with Quad Enable low gives `cmd_valid` = 0, and `io_oe` stays 0 for the rest of the transaction.
- R9: Commands 0x03 (no wait clocks) and 0x0B (8 wait clocks) read over one lane after a 24-clock one-lane address. `io_oe` is 4'b0010 from the falling edge after the last address or wait clock, and 0 before it. IO0 is never enabled for a one-lane read.
- R10: Chip select high clears the bit counter, any partial command, `cmd_valid`, `cmd_opcode`, the lane outputs and `io_oe`. It keeps `qpi_mode`.
- R11: In QPI every accepted command with an address uses four lanes for the address (6 clocks) and for the data. Wait clock counts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low; high clears the transaction |
| por_n | input | 1 | Power-on reset, active low; clears the mode flag |
| qe | input | 1 | Quad Enable status bit |
| io_in | input | 4 | Sampled levels of IO3..IO0 |
| cmd_opcode | output | 8 | Captured command byte |
| cmd_valid | output | 1 | Command recognised and allowed |
| cmd_lanes | output | 2 | Lane count of the command phase |
| addr_lanes | output | 2 | Lane count of the address phase |
| data_lanes | output | 2 | Lane count of the data phase |
| io_oe | output | 4 | Output enable per IO line |
| qpi_mode | output | 1 | 1 = QPI framing, 0 = SPI family |

## Verification
The bench hits each read exactly on the clock where data-out starts, and also one clock earlier. A phase counter that is off by one would raise `io_oe` too early or too late. It sends four-lane commands and 0x38 with Quad Enable low, so a missing gate would show enabled pins or a stray QPI entry. It drops chip select halfway through a nibble or a bit stream. A design that cleared the mode flag there, or kept the partial bits, would then decode the next command wrongly. The same commands are repeated with both clock polarities and in both framings, to expose a reversed nibble order or a missing four-lane override in QPI.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2
    } lane_e;

    typedef enum logic [1:0] {
        MODE_KEEP  = 2'd0,
        MODE_ENTER = 2'd1,
        MODE_LEAVE = 2'd2
    } mode_act_e;

    typedef enum logic [2:0] {
        ST_OPCODE   = 3'd0,
        ST_ADDR     = 3'd1,
        ST_DUMMY    = 3'd2,
        ST_DATA_IN  = 3'd3,
        ST_DATA_OUT = 3'd4,
        ST_DONE     = 3'd5,
        ST_IGNORE   = 3'd6
    } state_e;

    localparam int WAIT_W = 4;

    typedef struct packed {
        logic              valid;
        logic              has_addr;
        logic              has_data;
        logic              drives;
        lane_e             addr_lanes;
        lane_e             data_lanes;
        logic [WAIT_W-1:0] waits;
        mode_act_e         act;
    } dec_t;

    localparam logic [7:0] CMD_RD      = 8'h03;
    localparam logic [7:0] CMD_RD_FAST = 8'h0B;
    localparam logic [7:0] CMD_RD_2O   = 8'h3B;
    localparam logic [7:0] CMD_RD_2IO  = 8'hBB;
    localparam logic [7:0] CMD_RD_4O   = 8'h6B;
    localparam logic [7:0] CMD_RD_4IO  = 8'hEB;
    localparam logic [7:0] CMD_RD_4W   = 8'hE7;
    localparam logic [7:0] CMD_WR      = 8'h02;
    localparam logic [7:0] CMD_WR_4    = 8'h32;
    localparam logic [7:0] CMD_QPI_ON  = 8'h38;
    localparam logic [7:0] CMD_QPI_OFF = 8'hFF;
    localparam logic [7:0] CMD_RESET   = 8'h99;

endpackage

// File: rtl/fsf_opcode_shift.sv
module fsf_opcode_shift #(
    parameter int OP_W = 8
) (
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            en,
    input  logic            qpi,
    input  logic [3:0]      io_in,
    output logic [OP_W-1:0] op_next,
    output logic            done
);
    localparam int CNT_W = $clog2(OP_W);
    localparam logic [CNT_W-1:0] LAST_SER  = CNT_W'(OP_W - 1);
    localparam logic [CNT_W-1:0] LAST_QUAD = CNT_W'(OP_W / 4 - 1);

    logic [OP_W-2:0]  sh_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (qpi) op_next = {sh_q[OP_W-5:0], io_in};
        else     op_next = {sh_q[OP_W-2:0], io_in[0]};
        done = en && (cnt_q == (qpi ? LAST_QUAD : LAST_SER));
    end

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (en) begin
            sh_q  <= op_next[OP_W-2:0];
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fsf_decode.sv
module fsf_decode
    import fsf_pkg::*;
(
    input  logic [7:0] op,
    input  logic       qe,
    input  logic       qpi,
    output dec_t       dec
);
    always_comb begin
        dec            = '0;
        dec.addr_lanes = LANE_X1;
        dec.data_lanes = LANE_X1;
        dec.act        = MODE_KEEP;
        unique case (op)
            CMD_RD: begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1; dec.drives = 1'b1;
            end
            CMD_RD_FAST: begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1; dec.drives = 1'b1;
                dec.waits = WAIT_W'(8);
            end
            CMD_RD_2O: begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1; dec.drives = 1'b1;
                dec.data_lanes = LANE_X2; dec.waits = WAIT_W'(8);
            end
            CMD_RD_2IO: begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1; dec.drives = 1'b1;
                dec.addr_lanes = LANE_X2; dec.data_lanes = LANE_X2; dec.waits = WAIT_W'(4);
            end
            CMD_RD_4O: if (qe) begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1; dec.drives = 1'b1;
                dec.data_lanes = LANE_X4; dec.waits = WAIT_W'(8);
            end
            CMD_RD_4IO: if (qe) begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1; dec.drives = 1'b1;
                dec.addr_lanes = LANE_X4; dec.data_lanes = LANE_X4; dec.waits = WAIT_W'(6);
            end
            CMD_RD_4W: if (qe) begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1; dec.drives = 1'b1;
                dec.addr_lanes = LANE_X4; dec.data_lanes = LANE_X4; dec.waits = WAIT_W'(4);
            end
            CMD_WR: begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1;
            end
            CMD_WR_4: if (qe) begin
                dec.valid = 1'b1; dec.has_addr = 1'b1; dec.has_data = 1'b1;
                dec.data_lanes = LANE_X4;
            end
            CMD_QPI_ON: if (qe) begin
                dec.valid = 1'b1; dec.act = MODE_ENTER;
            end
            CMD_QPI_OFF, CMD_RESET: begin
                dec.valid = 1'b1; dec.act = MODE_LEAVE;
            end
            default: ;
        endcase
        if (qpi && dec.valid) begin
            if (dec.has_addr) dec.addr_lanes = LANE_X4;
            if (dec.has_data) dec.data_lanes = LANE_X4;
        end
    end
endmodule

// File: rtl/fsf_mode_reg.sv
module fsf_mode_reg (
    input  logic sclk,
    input  logic por_n,
    input  logic enter,
    input  logic leave,
    output logic qpi
);
    always_ff @(posedge sclk or negedge por_n) begin
        if (!por_n)     qpi <= 1'b0;
        else if (leave) qpi <= 1'b0;
        else if (enter) qpi <= 1'b1;
    end
endmodule

// File: rtl/fsf_cmd_frontend.sv
module fsf_cmd_frontend
    import fsf_pkg::*;
#(
    parameter int OP_W      = 8,
    parameter int ADDR_BITS = 24,
    parameter int CNT_W     = 5
) (
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            por_n,
    input  logic            qe,
    input  logic [3:0]      io_in,
    output logic [OP_W-1:0] cmd_opcode,
    output logic            cmd_valid,
    output logic [1:0]      cmd_lanes,
    output logic [1:0]      addr_lanes,
    output logic [1:0]      data_lanes,
    output logic [3:0]      io_oe,
    output logic            qpi_mode
);
    localparam logic [CNT_W-1:0] ACLK_X1 = CNT_W'(ADDR_BITS);
    localparam logic [CNT_W-1:0] ACLK_X2 = CNT_W'(ADDR_BITS / 2);
    localparam logic [CNT_W-1:0] ACLK_X4 = CNT_W'(ADDR_BITS / 4);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    state_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              load;
    logic [OP_W-1:0]   op_next;
    logic              op_done;
    dec_t              dec;
    logic [WAIT_W-1:0] waits_q;
    logic              drives_q, has_data_q;
    lane_e             addr_lanes_q, data_lanes_q;
    logic              mode_enter, mode_leave;

    fsf_opcode_shift #(.OP_W(OP_W)) u_shift (
        .sclk    (sclk),
        .cs_n    (cs_n),
        .en      (state_q == ST_OPCODE),
        .qpi     (qpi_mode),
        .io_in   (io_in),
        .op_next (op_next),
        .done    (op_done)
    );

    fsf_decode u_dec (
        .op  (op_next[7:0]),
        .qe  (qe),
        .qpi (qpi_mode),
        .dec (dec)
    );

    assign mode_enter = load && (dec.act == MODE_ENTER);
    assign mode_leave = load && (dec.act == MODE_LEAVE);

    fsf_mode_reg u_mode (
        .sclk  (sclk),
        .por_n (por_n),
        .enter (mode_enter),
        .leave (mode_leave),
        .qpi   (qpi_mode)
    );

    function automatic logic [CNT_W-1:0] addr_clocks(input lane_e l);
        case (l)
            LANE_X2: return ACLK_X2;
            LANE_X4: return ACLK_X4;
            default: return ACLK_X1;
        endcase
    endfunction

    function automatic state_e data_state(input logic has_data, input logic drives);
        if (!has_data) return ST_DONE;
        return drives ? ST_DATA_OUT : ST_DATA_IN;
    endfunction

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            ST_OPCODE: if (op_done) begin
                load = 1'b1;
                if (!dec.valid) begin
                    state_d = ST_IGNORE;
                end else if (dec.has_addr) begin
                    state_d = ST_ADDR;
                    cnt_d   = addr_clocks(dec.addr_lanes) - ONE;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_ADDR: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - ONE;
                end else if (waits_q != '0) begin
                    state_d = ST_DUMMY;
                    cnt_d   = CNT_W'(waits_q) - ONE;
                end else begin
                    state_d = data_state(has_data_q, drives_q);
                end
            end
            ST_DUMMY: begin
                if (cnt_q != '0) cnt_d = cnt_q - ONE;
                else             state_d = data_state(has_data_q, drives_q);
            end
            ST_DATA_IN, ST_DATA_OUT, ST_DONE, ST_IGNORE: ;
            default: state_d = ST_IGNORE;
        endcase
    end

    // State register and command capture
    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            state_q      <= ST_OPCODE;
            cnt_q        <= '0;
            cmd_opcode   <= '0;
            cmd_valid    <= 1'b0;
            waits_q      <= '0;
            drives_q     <= 1'b0;
            has_data_q   <= 1'b0;
            addr_lanes_q <= LANE_X1;
            data_lanes_q <= LANE_X1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) begin
                cmd_opcode   <= op_next;
                cmd_valid    <= dec.valid;
                waits_q      <= dec.waits;
                drives_q     <= dec.drives;
                has_data_q   <= dec.has_data;
                addr_lanes_q <= dec.addr_lanes;
                data_lanes_q <= dec.data_lanes;
            end
        end
    end

    // Output enables move on the falling edge
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            io_oe <= '0;
        end else if (state_q == ST_DATA_OUT) begin
            case (data_lanes_q)
                LANE_X2: io_oe <= 4'b0011;
                LANE_X4: io_oe <= 4'b1111;
                default: io_oe <= 4'b0010;
            endcase
        end else begin
            io_oe <= '0;
        end
    end

    assign cmd_lanes  = qpi_mode ? LANE_X4 : LANE_X1;
    assign addr_lanes = addr_lanes_q;
    assign data_lanes = data_lanes_q;
endmodule

// File: rtl/fsf_cmd_frontend_chk.sv
module fsf_cmd_frontend_chk (
    input logic       sclk,
    input logic       cs_n,
    input logic       por_n,
    input logic       qe,
    input logic       cmd_valid,
    input logic [1:0] data_lanes,
    input logic [3:0] io_oe,
    input logic       qpi_mode
);
    AST_OE_SHAPE: assert property (@(posedge sclk) disable iff (!por_n || cs_n)
        (io_oe == 4'h0 || io_oe == 4'h2 || io_oe == 4'h3 || io_oe == 4'hF)); // R1
    AST_IO0_QUIET_X1: assert property (@(posedge sclk) disable iff (!por_n || cs_n)
        (data_lanes == 2'd0) |-> !io_oe[0]); // R9
    AST_SINGLE_OE_LANE: assert property (@(posedge sclk) disable iff (!por_n || cs_n)
        (io_oe == 4'b0010) |-> (data_lanes == 2'd0)); // R9
    AST_OE_NEEDS_VALID: assert property (@(posedge sclk) disable iff (!por_n || cs_n)
        (io_oe != 4'h0) |-> cmd_valid); // R8
    AST_QUAD_NEEDS_QE: assert property (@(posedge sclk) disable iff (!por_n || cs_n)
        (io_oe == 4'hF && !qpi_mode) |-> qe); // R7
    AST_QPI_ENTRY_QE: assert property (@(posedge sclk) disable iff (!por_n)
        $rose(qpi_mode) |-> $past(qe)); // R4
    AST_CS_CLEARS: assert property (@(negedge cs_n) disable iff (!por_n)
        (io_oe == 4'h0 && !cmd_valid)); // R10
endmodule

bind fsf_cmd_frontend fsf_cmd_frontend_chk u_chk (
    .sclk       (sclk),
    .cs_n       (cs_n),
    .por_n      (por_n),
    .qe         (qe),
    .cmd_valid  (cmd_valid),
    .data_lanes (data_lanes),
    .io_oe      (io_oe),
    .qpi_mode   (qpi_mode)
);

// File: tb/fsf_cmd_frontend_tb.sv
module fsf_cmd_frontend_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic       sclk, cs_n, por_n, qe;
    logic [3:0] io_in;
    logic [7:0] cmd_opcode;
    logic       cmd_valid;
    logic [1:0] cmd_lanes, addr_lanes, data_lanes;
    logic [3:0] io_oe;
    logic       qpi_mode;

    fsf_cmd_frontend u_dut (
        .sclk(sclk), .cs_n(cs_n), .por_n(por_n), .qe(qe), .io_in(io_in),
        .cmd_opcode(cmd_opcode), .cmd_valid(cmd_valid), .cmd_lanes(cmd_lanes),
        .addr_lanes(addr_lanes), .data_lanes(data_lanes), .io_oe(io_oe),
        .qpi_mode(qpi_mode)
    );

    typedef struct {
        string      req;
        logic [7:0] op;
        logic       valid;
        logic [1:0] cl, al, dl;
        logic [3:0] oe;
        logic       qpi;
    } exp_t;

    exp_t q[$];
    event smp_ev;
    int   checks = 0;
    int   errors = 0;
    bit   ended  = 0;

    function automatic exp_t mk(string r, logic [7:0] op, logic v, logic [1:0] cl,
                                logic [1:0] al, logic [1:0] dl, logic [3:0] oe, logic qm);
        exp_t e;
        e.req = r; e.op = op; e.valid = v; e.cl = cl; e.al = al; e.dl = dl; e.oe = oe; e.qpi = qm;
        return e;
    endfunction

    // Monitor: compares outputs against the queued expectation
    initial begin
        forever begin
            @(smp_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cmd_opcode !== e.op || cmd_valid !== e.valid || cmd_lanes !== e.cl ||
                    addr_lanes !== e.al || data_lanes !== e.dl || io_oe !== e.oe ||
                    qpi_mode !== e.qpi) begin
                    errors++;
                    $display("FAIL %s: got op=%h v=%b cl=%0d al=%0d dl=%0d oe=%b qpi=%b exp op=%h v=%b cl=%0d al=%0d dl=%0d oe=%b qpi=%b",
                             e.req, cmd_opcode, cmd_valid, cmd_lanes, addr_lanes, data_lanes, io_oe, qpi_mode,
                             e.op, e.valid, e.cl, e.al, e.dl, e.oe, e.qpi);
                end
            end
        end
    end

    task automatic check_now(input exp_t e);
        q.push_back(e);
        -> smp_ev;
        #1;
    endtask

    // Driver: one transaction of nclk clocks, then a sample after the last falling edge
    task automatic run(input bit cpol, input bit quad_cmd, input logic [7:0] op,
                       input int nclk, input exp_t e);
        sclk = cpol;
        #HALF;
        cs_n = 1'b0;
        #HALF;
        for (int c = 0; c < nclk; c++) begin
            if (cpol) sclk = 1'b0;
            if (quad_cmd) io_in = (c == 0) ? op[7:4] : ((c == 1) ? op[3:0] : 4'h0);
            else          io_in = (c < 8) ? {3'b000, op[7 - c]} : 4'h0;
            #HALF;
            sclk = 1'b1;
            #HALF;
            if (!cpol) sclk = 1'b0;
        end
        if (cpol) sclk = 1'b0;
        #HALF;
        check_now(e);
        cs_n = 1'b1;
        #HALF;
        if (cpol) sclk = 1'b1;
        #CLK_PERIOD;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        sclk = 1'b0; cs_n = 1'b1; por_n = 1'b0; qe = 1'b0; io_in = 4'h0;
        #(2 * CLK_PERIOD);
        por_n = 1'b1;
        #(2 * CLK_PERIOD);
        check_now(mk("R5 power-on state", 8'h00, 0, 0, 0, 0, 4'h0, 0));

        // R9 single-lane read: enable exactly after address, not one clock before
        run(0, 0, 8'h03, 32, mk("R9 read x1 data-out", 8'h03, 1, 0, 0, 0, 4'b0010, 0));
        run(0, 0, 8'h03, 31, mk("R9 read x1 one clock early", 8'h03, 1, 0, 0, 0, 4'h0, 0));
        // R1 idle-high clock
        run(1, 0, 8'h0B, 40, mk("R1 mode3 fast read", 8'h0B, 1, 0, 0, 0, 4'b0010, 0));
        run(1, 0, 8'h0B, 39, mk("R1 mode3 fast read early", 8'h0B, 1, 0, 0, 0, 4'h0, 0));
        // R6 two-lane reads, R2 bit order
        run(0, 0, 8'h3B, 40, mk("R6 R2 dual out", 8'h3B, 1, 0, 0, 1, 4'b0011, 0));
        run(1, 0, 8'hBB, 24, mk("R6 dual io", 8'hBB, 1, 0, 1, 1, 4'b0011, 0));
        run(0, 0, 8'hBB, 23, mk("R6 dual io early", 8'hBB, 1, 0, 1, 1, 4'h0, 0));
        // R8 four-lane commands without Quad Enable
        run(0, 0, 8'hEB, 30, mk("R8 quad io no qe", 8'hEB, 0, 0, 0, 0, 4'h0, 0));
        run(0, 0, 8'h6B, 40, mk("R8 quad out no qe", 8'h6B, 0, 0, 0, 0, 4'h0, 0));
        // R7 four-lane commands with Quad Enable
        qe = 1'b1;
        run(0, 0, 8'hEB, 20, mk("R7 quad io", 8'hEB, 1, 0, 2, 2, 4'hF, 0));
        run(0, 0, 8'h6B, 40, mk("R7 quad out", 8'h6B, 1, 0, 0, 2, 4'hF, 0));
        run(1, 0, 8'hE7, 18, mk("R7 quad word", 8'hE7, 1, 0, 2, 2, 4'hF, 0));
        run(0, 0, 8'h32, 40, mk("R7 quad write", 8'h32, 1, 0, 0, 2, 4'h0, 0));
        run(0, 0, 8'h02, 40, mk("R2 single write", 8'h02, 1, 0, 0, 0, 4'h0, 0));
        // R4 QPI entry gated by Quad Enable
        qe = 1'b0;
        run(0, 0, 8'h38, 8, mk("R4 enter refused", 8'h38, 0, 0, 0, 0, 4'h0, 0));
        qe = 1'b1;
        run(0, 0, 8'h38, 8, mk("R4 enter", 8'h38, 1, 2, 0, 0, 4'h0, 1));
        // R3 / R11 QPI framing
        run(0, 1, 8'h03, 8, mk("R3 R11 qpi read", 8'h03, 1, 2, 2, 2, 4'hF, 1));
        run(1, 1, 8'h0B, 16, mk("R11 qpi fast read mode3", 8'h0B, 1, 2, 2, 2, 4'hF, 1));
        run(0, 1, 8'h3B, 16, mk("R11 qpi dual cmd widened", 8'h3B, 1, 2, 2, 2, 4'hF, 1));
        // R10 partial nibble then a full command; mode kept
        run(0, 1, 8'hEB, 1, mk("R10 partial nibble", 8'h00, 0, 2, 0, 0, 4'h0, 1));
        run(0, 1, 8'hEB, 14, mk("R10 after partial", 8'hEB, 1, 2, 2, 2, 4'hF, 1));
        // R5 leave QPI
        run(0, 1, 8'hFF, 2, mk("R5 leave via FF", 8'hFF, 1, 0, 0, 0, 4'h0, 0));
        run(0, 0, 8'h03, 4, mk("R10 partial byte", 8'h00, 0, 0, 0, 0, 4'h0, 0));
        run(0, 0, 8'h0B, 40, mk("R10 after partial byte", 8'h0B, 1, 0, 0, 0, 4'b0010, 0));
        run(0, 0, 8'h38, 8, mk("R4 re-enter", 8'h38, 1, 2, 0, 0, 4'h0, 1));
        run(1, 1, 8'h99, 2, mk("R5 leave via 99", 8'h99, 1, 0, 0, 0, 4'h0, 0));
        run(0, 0, 8'h38, 8, mk("R4 enter before por", 8'h38, 1, 2, 0, 0, 4'h0, 1));
        por_n = 1'b0;
        #CLK_PERIOD;
        por_n = 1'b1;
        #CLK_PERIOD;
        check_now(mk("R5 por clears qpi", 8'h00, 0, 0, 0, 0, 4'h0, 0));

        #CLK_PERIOD;
        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule